// File: doc/BRIEF.md
# Cartridge Page-Frame Memory Mapper

This block turns the 16-bit address bus of an 8-bit processor into selects and extended addresses for a banked cartridge ROM, two pages of auxiliary RAM, and 8 KB of work RAM. The lower three quarters of the address space are split into three 16 KB windows. Each window shows one 16 KB ROM page chosen by a bank register. The ROM holds up to 32 pages (512 KB), so the ROM address is 19 bits wide. The third window can show one of two auxiliary RAM pages in place of its ROM page.

The top quarter of the address space decodes to work RAM. It holds the 8 KB array twice, at $C000–$DFFF and again at $E000–$FFFF. The four bank registers sit at the top four addresses $FFFC–$FFFF. A write there loads the register and also stores the byte into work RAM through the mirror, at $1FFC–$1FFF of the array. Reads of those addresses are served by the RAM, which already holds the last value written.

The block drives only selects and addresses. The memory arrays sit outside it. All four registers are also presented together on a readback output.

Top module: `page_mapper_top`

## Requirements
- R1: After reset the readback is ctrl=$00, window0 page=0, window1 page=1, window2 page=2, so the auxiliary RAM starts disabled. The readback packs ctrl in bits [7:0], window0 in [15:8], window1 in [23:16] and window2 in [31:24].
- R2: A read or write at $0000–$3FFF asserts the ROM select with ROM address {window0 page[4:0], cpu_addr[13:0]}.
- R3: A read or write at $4000–$7FFF asserts the ROM select with ROM address {window1 page[4:0], cpu_addr[13:0]}.
- R4: A read or write at $8000–$BFFF while ctrl bit 3 is 0 asserts the ROM select with ROM address {window2 page[4:0], cpu_addr[13:0]}.
- R5: A read or write at $8000–$BFFF while ctrl bit 3 is 1 asserts the auxiliary select instead of the ROM select, with auxiliary address {ctrl bit 2, cpu_addr[13:0]}.
- R6: A read or write at $C000–$FFFF asserts the work-RAM select with work-RAM address cpu_addr[12:0], so both halves of that range reach the same bytes.
- R7: A write to $FFFC, $FFFD, $FFFE or $FFFF also asserts the work-RAM select, with address $1FFC–$1FFF. On the next clock edge the write loads ctrl, window0, window1 or window2, in that address order.
- R8: A register write takes effect only from the clock edge that ends the write cycle. Selects and addresses in the write cycle itself use the old mapping.
- R9: Two or three windows may hold the same page number, and each then produces the same ROM page.
- R10: Writes to any address below $FFFC leave all four registers unchanged.
- R11: Only bits [4:0] of a window register form the ROM page. All eight bits of every register read back exactly as written.
- R12: With neither strobe asserted, no select is active. At most one select is ever active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| rom_cs | output | 1 | Cartridge ROM select |
| rom_addr | output | 19 | Extended ROM address |
| wram_cs | output | 1 | Work-RAM select |
| wram_addr | output | 13 | Work-RAM address |
| aux_cs | output | 1 | Auxiliary RAM select |
| aux_addr | output | 15 | Auxiliary RAM address (page bit plus offset) |
| regs_out | output | 32 | Readback of the four bank registers |

## Verification
The assertions assume a single access per cycle. They also assume that the strobes, address and write data are stable from one clock edge to the next, with no cycle asserting both strobes.

The stimulus is driven on the falling edge and never raises read and write together. Register writes are issued as complete single-cycle accesses, so the loading and hold properties always see a well-defined address.

A behavioural model of the four registers predicts every select and address. The bench compares the model against the design once per cycle, through directed cases and a run of random accesses.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    // Control register bit positions
    localparam int CTRL_AUX_SEL = 2;
    localparam int CTRL_AUX_EN  = 3;

    typedef struct packed {
        logic [7:0] win2;
        logic [7:0] win1;
        logic [7:0] win0;
        logic [7:0] ctrl;
    } bank_regs_t;

    localparam bank_regs_t BANK_RESET = '{win2: 8'd2, win1: 8'd1, win0: 8'd0, ctrl: 8'd0};

endpackage

// File: rtl/bank_regs.sv
module bank_regs
    import mapper_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output bank_regs_t        regs_q
);

    logic       reg_hit;
    bank_regs_t regs_d;

    // The registers occupy the four highest addresses
    assign reg_hit = wr_en && (&addr[ADDR_W-1:2]);

    always_comb begin
        regs_d = regs_q;
        if (reg_hit) begin
            case (addr[1:0])
                2'd0:    regs_d.ctrl = wdata;
                2'd1:    regs_d.win0 = wdata;
                2'd2:    regs_d.win1 = wdata;
                default: regs_d.win2 = wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= BANK_RESET;
        else        regs_q <= regs_d;
    end

    // R7: a write to the top address lands in window2 on the next edge
    assert_load_win2_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == {ADDR_W{1'b1}}) |=> regs_q.win2 == $past(wdata));

    // R7: a write to the lowest register address lands in ctrl
    assert_load_ctrl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ({ADDR_W{1'b1}} - ADDR_W'(3))) |=> regs_q.ctrl == $past(wdata));

    // R10: no register changes without a write to the register block
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr >= ({ADDR_W{1'b1}} - ADDR_W'(3))) |=> $stable(regs_q));

endmodule

// File: rtl/addr_decode.sv
module addr_decode #(
    parameter int ADDR_W     = 16,
    parameter int FRAME_BITS = 14,
    parameter int PAGE_BITS  = 5,
    parameter int WRAM_BITS  = 13
) (
    input  logic [ADDR_W-1:0]                         addr,
    input  logic                                      access,
    input  logic [(1<<(ADDR_W-FRAME_BITS))-2:0][PAGE_BITS-1:0] frame_page,
    input  logic                                      aux_en,
    input  logic                                      aux_sel,
    output logic                                      rom_cs,
    output logic [PAGE_BITS+FRAME_BITS-1:0]           rom_addr,
    output logic                                      wram_cs,
    output logic [WRAM_BITS-1:0]                      wram_addr,
    output logic                                      aux_cs,
    output logic [FRAME_BITS:0]                       aux_addr
);

    localparam int SLOT_W = ADDR_W - FRAME_BITS;
    localparam int NSLOT  = 1 << SLOT_W;

    logic [SLOT_W-1:0]    slot;
    logic [NSLOT-1:0]     slot_hit;
    logic [PAGE_BITS-1:0] page_pick;
    logic                 cart_area;
    logic                 aux_window;

    assign slot = addr[ADDR_W-1:FRAME_BITS];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign slot_hit[g] = (slot == SLOT_W'(g));
    end

    always_comb begin
        page_pick = '0;
        for (int i = 0; i < NSLOT-1; i++) begin
            if (slot_hit[i]) page_pick = frame_page[i];
        end
    end

    // The last slot is work RAM, and the slot below it is the banked window
    assign cart_area  = ~slot_hit[NSLOT-1];
    assign aux_window = slot_hit[NSLOT-2] & aux_en;

    assign rom_cs    = access & cart_area & ~aux_window;
    assign rom_addr  = {page_pick, addr[FRAME_BITS-1:0]};
    assign aux_cs    = access & aux_window;
    assign aux_addr  = {aux_sel, addr[FRAME_BITS-1:0]};
    assign wram_cs   = access & slot_hit[NSLOT-1];
    assign wram_addr = addr[WRAM_BITS-1:0];

endmodule

// File: rtl/page_mapper_top.sv
module page_mapper_top
    import mapper_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int FRAME_BITS = 14,
    parameter int PAGE_BITS  = 5,
    parameter int WRAM_BITS  = 13
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             cpu_addr,
    input  logic                          cpu_rd,
    input  logic                          cpu_wr,
    input  logic [7:0]                    cpu_wdata,
    output logic                          rom_cs,
    output logic [PAGE_BITS+FRAME_BITS-1:0] rom_addr,
    output logic                          wram_cs,
    output logic [WRAM_BITS-1:0]          wram_addr,
    output logic                          aux_cs,
    output logic [FRAME_BITS:0]           aux_addr,
    output logic [31:0]                   regs_out
);

    localparam int NWIN = (1 << (ADDR_W - FRAME_BITS)) - 1;

    bank_regs_t                           regs_q;
    logic [NWIN-1:0][PAGE_BITS-1:0]       frame_page;

    bank_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cpu_wr),
        .addr   (cpu_addr),
        .wdata  (cpu_wdata),
        .regs_q (regs_q)
    );

    assign frame_page[0] = regs_q.win0[PAGE_BITS-1:0];
    assign frame_page[1] = regs_q.win1[PAGE_BITS-1:0];
    assign frame_page[2] = regs_q.win2[PAGE_BITS-1:0];

    addr_decode #(
        .ADDR_W(ADDR_W), .FRAME_BITS(FRAME_BITS),
        .PAGE_BITS(PAGE_BITS), .WRAM_BITS(WRAM_BITS)
    ) u_dec (
        .addr       (cpu_addr),
        .access     (cpu_rd | cpu_wr),
        .frame_page (frame_page),
        .aux_en     (regs_q.ctrl[CTRL_AUX_EN]),
        .aux_sel    (regs_q.ctrl[CTRL_AUX_SEL]),
        .rom_cs     (rom_cs),
        .rom_addr   (rom_addr),
        .wram_cs    (wram_cs),
        .wram_addr  (wram_addr),
        .aux_cs     (aux_cs),
        .aux_addr   (aux_addr)
    );

    assign regs_out = regs_q;

    // R12: selects are mutually exclusive
    assert_one_select_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_cs, wram_cs, aux_cs}));

    // R12: no select without a strobe
    assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd || cpu_wr) |-> !(rom_cs || wram_cs || aux_cs));

    // R5: auxiliary RAM only appears in the banked window
    assert_aux_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        aux_cs |-> cpu_addr[ADDR_W-1 -: 2] == 2'b10);

    // R6: work RAM only in the top quarter
    assert_wram_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wram_cs |-> cpu_addr[ADDR_W-1 -: 2] == 2'b11);

endmodule

// File: tb/tb_page_mapper_top.sv
module tb_page_mapper_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic        rom_cs, wram_cs, aux_cs;
    logic [18:0] rom_addr;
    logic [12:0] wram_addr;
    logic [14:0] aux_addr;
    logic [31:0] regs_out;

    int total = 0;
    int bad = 0;
    logic [7:0] m [4];   // model: ctrl, win0, win1, win2

    always #4 clk = ~clk;

    page_mapper_top dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .rom_cs(rom_cs),
        .rom_addr(rom_addr), .wram_cs(wram_cs), .wram_addr(wram_addr),
        .aux_cs(aux_cs), .aux_addr(aux_addr), .regs_out(regs_out)
    );

    task automatic model_reset();
        m[0] = 8'd0; m[1] = 8'd0; m[2] = 8'd1; m[3] = 8'd2;
    endtask

    task automatic compare(input string tag_in);
        logic        acc, e_rom, e_wram, e_aux;
        logic [18:0] e_ra;
        logic [12:0] e_wa;
        logic [14:0] e_aa;
        logic [31:0] e_regs;
        logic [99:0] exp_v, act_v;
        string       tag;
        int          fr;
        acc = cpu_rd | cpu_wr;
        fr  = int'(cpu_addr[15:14]);
        e_rom = 0; e_wram = 0; e_aux = 0; e_ra = '0; e_wa = '0; e_aa = '0;
        tag = tag_in;
        if (!acc) begin
            if (tag == "") tag = "R12";
        end else if (fr == 3) begin
            e_wram = 1; e_wa = cpu_addr[12:0];
            if (tag == "") tag = (cpu_wr && cpu_addr >= 16'hFFFC) ? "R7" : "R6";
        end else if (fr == 2 && m[0][3]) begin
            e_aux = 1; e_aa = {m[0][2], cpu_addr[13:0]};
            if (tag == "") tag = "R5";
        end else begin
            e_rom = 1; e_ra = {m[fr+1][4:0], cpu_addr[13:0]};
            if (tag == "") tag = (fr == 0) ? "R2" : (fr == 1) ? "R3" : "R4";
        end
        e_regs = {m[3], m[2], m[1], m[0]};
        exp_v = {e_rom, e_ra, e_wram, e_wa, e_aux, e_aa, e_regs};
        act_v = {rom_cs, rom_cs ? rom_addr : 19'd0, wram_cs, wram_cs ? wram_addr : 13'd0,
                 aux_cs, aux_cs ? aux_addr : 15'd0, regs_out};
        total++;
        if (act_v !== exp_v) begin
            bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, cpu_addr, act_v, exp_v);
        end
    endtask

    task automatic step(input logic [15:0] a, input logic wr, input logic rd,
                        input logic [7:0] d, input string tag);
        @(negedge clk);
        cpu_addr = a; cpu_wr = wr; cpu_rd = rd; cpu_wdata = d;
        #1;
        compare(tag);
        @(posedge clk);
        if (wr && a >= 16'hFFFC) m[a[1:0]] = d;
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        step(16'h0000, 0, 1, 8'h00, "R1");           // R1 reset mapping
        step(16'h1234, 0, 1, 8'h00, "R2");
        step(16'h5678, 0, 1, 8'h00, "R3");
        step(16'h9ABC, 0, 1, 8'h00, "R4");
        step(16'hFFFD, 1, 0, 8'h07, "R8");           // R8 old mapping in write cycle
        step(16'h0010, 0, 1, 8'h00, "R7");           // R7 new page 7 in window0
        step(16'hFFFF, 1, 0, 8'h1F, "R7");
        step(16'hBFFF, 0, 1, 8'h00, "R11");          // R11 page 31 boundary
        step(16'hFFFF, 1, 0, 8'hE3, "R7");
        step(16'h8000, 0, 1, 8'h00, "R11");          // R11 upper bits ignored, read back
        step(16'hFFFC, 1, 0, 8'h08, "R7");
        step(16'h8001, 0, 1, 8'h00, "R5");           // R5 aux page 0
        step(16'hFFFC, 1, 0, 8'h0C, "R7");
        step(16'hBFFE, 1, 0, 8'h55, "R5");           // R5 aux page 1 write
        step(16'hFFFC, 1, 0, 8'hF3, "R11");          // R11 aux off, bits kept
        step(16'h8000, 0, 1, 8'h00, "R4");
        step(16'hFFFD, 1, 0, 8'h04, "R9");
        step(16'hFFFE, 1, 0, 8'h04, "R9");
        step(16'hFFFF, 1, 0, 8'h04, "R9");
        step(16'h0100, 0, 1, 8'h00, "R9");
        step(16'h4100, 0, 1, 8'h00, "R9");
        step(16'h8100, 0, 1, 8'h00, "R9");
        step(16'hC000, 1, 0, 8'hAA, "R10");          // R10 ignored writes
        step(16'hDFFF, 1, 0, 8'hAA, "R10");
        step(16'hFFFB, 1, 0, 8'hAA, "R10");
        step(16'h0000, 1, 0, 8'hAA, "R10");
        step(16'hBFFF, 1, 0, 8'hAA, "R10");
        step(16'h4000, 0, 1, 8'h00, "R10");
        step(16'hC123, 0, 1, 8'h00, "R6");
        step(16'hE123, 0, 1, 8'h00, "R6");           // R6 mirror
        step(16'hFFFE, 0, 1, 8'h00, "R6");
        step(16'h1234, 0, 0, 8'h00, "R12");          // R12 idle
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            logic        w, r;
            a = 16'($urandom);
            if (i % 5 == 0) a = 16'hFFFC | 16'(i[1:0]);
            w = ($urandom % 3) == 0;
            r = !w && (($urandom % 4) != 0);
            step(a, w, r, 8'($urandom), "");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule